// File: doc/BRIEF.md
# Misaligned Access Line Splitter

This block sits between a single load/store requester and a memory that is organised as two interleaved banks of 16-byte lines. Even lines (address bit 4 clear) live behind memory port 0 and odd lines (address bit 4 set) live behind memory port 1. A request carries a byte address, a byte count from 1 to 16 and, for stores, up to 16 bytes of data. The byte count is a plain binary number.

A request that fits inside one line produces one memory request on the port that owns that line. A request that crosses a 16-byte boundary produces two partial requests. One covers the tail of the first line and the other covers the head of the following line. Because consecutive lines alternate between banks, the two halves always land on different ports. Each partial request carries its own line address, 16-bit byte enable and byte-shifted write data.

For loads, the block waits until every port it addressed has answered, in either order and with any latency. It then realigns the two returned lines into a single right-justified result and presents it with a one-cycle valid pulse. For stores, the block reports completion one cycle after the write is issued. The requester sees a busy flag for as long as a request is in flight.

Top module: `line_split_unit`

## Requirements
- R1: After reset, busy, response valid and both memory requests are low. A request is taken when `req_valid_i` is high and busy is low. Busy is high from the cycle after acceptance up to and including the response cycle, and low the cycle after that.
- R2: A request presented while busy is high has no effect: it issues no memory request and changes no memory contents.
- R3: Memory port 0 only ever receives line addresses whose bit 0 (address bit 4) is 0, and port 1 only those whose bit 0 is 1. The line address is address bits [ADDR_W-1:4]. The line holding the start address is the first line, and the line that follows it, at the first line address plus 1 (wrapping), is the next line.
- R4: Form a 32-bit span mask by taking ((1<<len)-1) and shifting it left by the address bits [3:0]. Bits [15:0] of this mask are the byte enables of the first line. Bits [31:16] are the byte enables of the next line, which the other port carries. When both ports are requested, their line addresses differ by exactly one. Bytes outside the request stay unchanged.
- R5: A port whose byte enables are all zero receives no request. Every port with a nonzero enable receives exactly one single-cycle request, one cycle after acceptance. `mem_we_o` is high on a request exactly when the operation is a store.
- R6: For a store, place write-data byte k at byte position (addr[3:0]+k) of a 32-byte span. The port of the first line receives span bytes 0..15, and the other port receives bytes 16..31.
- R7: A store completes with `rsp_valid_o` high for exactly one cycle, two cycles after acceptance (the cycle after the memory request), with `rsp_rdata_o` zero.
- R8: A load waits for a read-valid pulse from every port it requested, arriving at least one cycle after the request in either order. `rsp_valid_o` pulses for one cycle, the cycle after the last of these pulses is taken.
- R9: In a load result, byte k (k < len) equals the memory byte at address addr+k (wrapping), and every byte at position len or above is zero.
- R10: Every start offset 0..15 combined with every length 1..16 is handled, including a crossing from the top line of the address space back to line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_len_i | input | 5 | Byte count, 1..16 |
| req_wdata_i | input | 128 | Store data, byte 0 in bits [7:0] |
| req_busy_o | output | 1 | Request in flight |
| rsp_valid_o | output | 1 | One-cycle completion / load data valid |
| rsp_rdata_o | output | 128 | Right-justified load data |
| mem_req_o | output | 2 | Per-port request pulse |
| mem_we_o | output | 2 | Per-port write enable |
| mem_line_o | output | 2 x (ADDR_W-4) | Per-port line address |
| mem_be_o | output | 2 x 16 | Per-port byte enables |
| mem_wdata_o | output | 2 x 128 | Per-port write line data |
| mem_rvalid_i | input | 2 | Per-port read data valid |
| mem_rdata_i | input | 2 x 128 | Per-port read line data |

## Verification
The stimulus sweeps every start offset and every length, starting from an even line, from an odd line and from the top line where the next line wraps to zero. This separates requests that stay in one line from requests that cross a line, and it tests both port orderings. Each store is read back at its own address and length, and the two whole lines around it are read as well, so that wrong enables that disturb neighbouring bytes are detected. Read latencies of the two ports are varied from one request to the next, so that the first line's data can arrive before, after or together with the next line's data. Requests made while the block is busy are checked against an untouched region.

// File: rtl/lsplit_pkg.sv
// Shared constants and types for the line splitter.
// Assumes 16-byte lines and 128-bit memory ports.
package lsplit_pkg;
    localparam int LINE_BYTES = 16;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int DATA_W     = LINE_BYTES * 8;
    localparam int LEN_W      = OFF_W + 1;
    localparam int NPORT      = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } lsplit_state_e;
endpackage

// File: rtl/line_split_decode.sv
// Turns an address, length and store data into per-port line address,
// byte enables and shifted write data. Purely combinational.
// Assumes len is 1..16; a value above 16 behaves as 16.
module line_split_decode
    import lsplit_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [LEN_W-1:0]                   len,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NPORT-1:0][LINE_W-1:0]       line,
    output logic [NPORT-1:0][LINE_BYTES-1:0]   be,
    output logic [NPORT-1:0][DATA_W-1:0]       pdata
);
    logic [OFF_W-1:0]          off;
    logic [LINE_W-1:0]         first_line;
    logic [LINE_W-1:0]         next_line;
    logic [LINE_BYTES:0]       len_mask;
    logic [2*LINE_BYTES-1:0]   span_mask;
    logic [2*DATA_W-1:0]       span_data;

    // Build the 32-byte span mask and shifted span data.
    always_comb begin
        off        = addr[OFF_W-1:0];
        first_line = addr[ADDR_W-1:OFF_W];
        next_line  = first_line + LINE_W'(1);
        if (len > LEN_W'(LINE_BYTES))
            len_mask = {1'b0, {LINE_BYTES{1'b1}}};
        else
            len_mask = ((LINE_BYTES+1)'(1) << len) - (LINE_BYTES+1)'(1);
        span_mask  = {{LINE_BYTES{1'b0}}, len_mask[LINE_BYTES-1:0]} << off;
        span_data  = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
    end

    // Each port takes the half whose line parity matches its index.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic owns_first;
        // Pick first-line or next-line half for this port.
        always_comb begin
            owns_first = (first_line[0] == 1'(p));
            line[p]    = owns_first ? first_line : next_line;
            be[p]      = owns_first ? span_mask[LINE_BYTES-1:0]
                                    : span_mask[2*LINE_BYTES-1:LINE_BYTES];
            pdata[p]   = owns_first ? span_data[DATA_W-1:0]
                                    : span_data[2*DATA_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/line_port_capture.sv
// Holds the read line returned by one memory port and a flag that it
// has arrived. Cleared when a new request is accepted.
module line_port_capture
    import lsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [DATA_W-1:0] rdata,
    output logic              got,
    output logic [DATA_W-1:0] data
);
    // Latch the first returned line per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got  <= 1'b0;
            data <= '0;
        end else if (clear) begin
            got  <= 1'b0;
        end else if (take && !got) begin
            got  <= 1'b1;
            data <= rdata;
        end
    end
endmodule

// File: rtl/line_merge.sv
// Rebuilds a load result from the first and next line: joins them into a
// 32-byte span, shifts it down by the offset and clears bytes past len.
module line_merge
    import lsplit_pkg::*;
(
    input  logic                          first_port,
    input  logic [OFF_W-1:0]              off,
    input  logic [LEN_W-1:0]              len,
    input  logic [NPORT-1:0][DATA_W-1:0]  line_data,
    output logic [DATA_W-1:0]             result
);
    logic [2*DATA_W-1:0] span;
    logic [2*DATA_W-1:0] shifted;

    // Order the two lines and realign to byte 0.
    always_comb begin
        span    = first_port ? {line_data[0], line_data[1]}
                             : {line_data[1], line_data[0]};
        shifted = span >> {off, 3'b000};
    end

    // Keep only the requested bytes.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign result[b*8 +: 8] = (LEN_W'(b) < len) ? shifted[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/line_split_unit.sv
// Splits one load/store over two memory ports serving even and odd
// 16-byte lines, and merges load data back. Assumes memory accepts every
// request at once and returns read data at least one cycle later.
module line_split_unit
    import lsplit_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int LINE_W = ADDR_W - 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid_i,
    input  logic                              req_store_i,
    input  logic [ADDR_W-1:0]                 req_addr_i,
    input  logic [4:0]                        req_len_i,
    input  logic [127:0]                      req_wdata_i,
    output logic                              req_busy_o,
    output logic                              rsp_valid_o,
    output logic [127:0]                      rsp_rdata_o,
    output logic [1:0]                        mem_req_o,
    output logic [1:0]                        mem_we_o,
    output logic [1:0][LINE_W-1:0]            mem_line_o,
    output logic [1:0][15:0]                  mem_be_o,
    output logic [1:0][127:0]                 mem_wdata_o,
    input  logic [1:0]                        mem_rvalid_i,
    input  logic [1:0][127:0]                 mem_rdata_i
);
    lsplit_state_e              state;
    logic                       accept;
    logic [ADDR_W-1:0]          r_addr;
    logic [LEN_W-1:0]           r_len;
    logic                       r_store;
    logic [DATA_W-1:0]          r_wdata;
    logic [NPORT-1:0]           active;
    logic [NPORT-1:0]           got;
    logic [NPORT-1:0]           arrived;
    logic [NPORT-1:0][DATA_W-1:0] cap_data;
    logic [DATA_W-1:0]          merged;
    logic                       all_in;

    assign accept = req_valid_i && (state == ST_IDLE);

    // Register the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_len   <= '0;
            r_store <= 1'b0;
            r_wdata <= '0;
        end else if (accept) begin
            r_addr  <= req_addr_i;
            r_len   <= req_len_i;
            r_store <= req_store_i;
            r_wdata <= req_wdata_i;
        end
    end

    line_split_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (r_addr),
        .len   (r_len),
        .wdata (r_wdata),
        .line  (mem_line_o),
        .be    (mem_be_o),
        .pdata (mem_wdata_o)
    );

    // Per-port request, write enable and arrival tracking.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign active[p]    = |mem_be_o[p];
        assign mem_req_o[p] = (state == ST_ISSUE) && active[p];
        assign mem_we_o[p]  = mem_req_o[p] && r_store;
        assign arrived[p]   = got[p] || (mem_rvalid_i[p] && active[p]) || !active[p];

        line_port_capture u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (accept),
            .take  ((state == ST_WAIT) && active[p] && mem_rvalid_i[p]),
            .rdata (mem_rdata_i[p]),
            .got   (got[p]),
            .data  (cap_data[p])
        );
    end

    assign all_in = &arrived;

    // Sequence: idle, issue, wait for reads, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= ST_ISSUE;
                ST_ISSUE: state <= r_store ? ST_RESP : ST_WAIT;
                ST_WAIT:  if (all_in) state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    line_merge u_merge (
        .first_port (r_addr[OFF_W]),
        .off        (r_addr[OFF_W-1:0]),
        .len        (r_len),
        .line_data  (cap_data),
        .result     (merged)
    );

    assign req_busy_o  = (state != ST_IDLE);
    assign rsp_valid_o = (state == ST_RESP);
    assign rsp_rdata_o = (rsp_valid_o && !r_store) ? merged : '0;
endmodule

// File: rtl/line_split_chk.sv
// Protocol checks for line_split_unit, attached by bind.
module line_split_chk #(
    parameter int ADDR_W = 16,
    localparam int LINE_W = ADDR_W - 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid_i,
    input logic [4:0]             req_len_i,
    input logic                   req_busy_o,
    input logic                   rsp_valid_o,
    input logic [1:0]             mem_req_o,
    input logic [1:0][LINE_W-1:0] mem_line_o,
    input logic [1:0][15:0]       mem_be_o
);
    logic [4:0] seen_len;

    // Remember the length of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                          seen_len <= '0;
        else if (req_valid_i && !req_busy_o) seen_len <= req_len_i;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_busy_o) |=> req_busy_o); // R1
    AST_RSP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> (!rsp_valid_o && !req_busy_o)); // R7
    AST_PORT0_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[0] |-> !mem_line_o[0][0]); // R3
    AST_PORT1_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[1] |-> mem_line_o[1][0]); // R3
    AST_LINES_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (&mem_req_o) |-> ((mem_line_o[1] == mem_line_o[0] + LINE_W'(1)) ||
                          (mem_line_o[0] == mem_line_o[1] + LINE_W'(1)))); // R4
    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_req_o) |-> ($countones(mem_be_o) == 32'(seen_len))); // R4
    AST_REQ0_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[0] |-> (mem_be_o[0] != 16'h0)); // R5
    AST_REQ1_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[1] |-> (mem_be_o[1] != 16'h0)); // R5
    AST_REQ0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[0] |=> !mem_req_o[0]); // R5
    AST_REQ1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o[1] |=> !mem_req_o[1]); // R5
endmodule

bind line_split_unit line_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_len_i   (req_len_i),
    .req_busy_o  (req_busy_o),
    .rsp_valid_o (rsp_valid_o),
    .mem_req_o   (mem_req_o),
    .mem_line_o  (mem_line_o),
    .mem_be_o    (mem_be_o)
);

// File: tb/sim_line_split_unit.sv
// Sweeps offsets and lengths on an 8-bit address space with a byte
// memory model behind the two ports and a separate reference copy.
module sim_line_split_unit;
    localparam int AW = 8;
    localparam int LW = AW - 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid_i = 1'b0;
    logic                  req_store_i = 1'b0;
    logic [AW-1:0]         req_addr_i = '0;
    logic [4:0]            req_len_i = 5'd1;
    logic [127:0]          req_wdata_i = '0;
    logic                  req_busy_o;
    logic                  rsp_valid_o;
    logic [127:0]          rsp_rdata_o;
    logic [1:0]            mem_req_o;
    logic [1:0]            mem_we_o;
    logic [1:0][LW-1:0]    mem_line_o;
    logic [1:0][15:0]      mem_be_o;
    logic [1:0][127:0]     mem_wdata_o;
    logic [1:0]            mem_rvalid_i;
    logic [1:0][127:0]     mem_rdata_i;

    int total = 0;
    int fails = 0;
    int opn = 0;
    int lat [2];
    int cnt [2];
    logic [7:0] bmem [256];
    logic [7:0] rmem [256];
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    line_split_unit #(.ADDR_W(AW)) u0 (.*);

    // Memory model: byte writes by enable, line reads with set latency.
    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (!rst_n) begin
                cnt[p] <= 0;
            end else if (mem_req_o[p]) begin
                if (mem_we_o[p]) begin
                    for (int i = 0; i < 16; i++)
                        if (mem_be_o[p][i]) bmem[{mem_line_o[p], 4'(i)}] <= mem_wdata_o[p][i*8 +: 8];
                end else begin
                    for (int i = 0; i < 16; i++)
                        mem_rdata_i[p][i*8 +: 8] <= bmem[{mem_line_o[p], 4'(i)}];
                    cnt[p] <= lat[p];
                end
            end else if (cnt[p] > 0) begin
                cnt[p] <= cnt[p] - 1;
            end
        end
        if (!rst_n)
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i * 37 + 5);
    end

    assign mem_rvalid_i[0] = (cnt[0] == 1);
    assign mem_rvalid_i[1] = (cnt[1] == 1);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_load(input logic [7:0] a, input int len);
        logic [127:0] r = '0;
        for (int k = 0; k < len; k++) r[k*8 +: 8] = rmem[8'(a + 8'(k))];
        return r;
    endfunction

    // One full operation; starts and ends just after a falling edge.
    task automatic do_op(input bit st, input logic [7:0] a, input int len,
                         input logic [127:0] wd, input bit poke, output logic [127:0] rd);
        logic [31:0]       m32;
        logic [255:0]      span;
        logic [1:0][15:0]  be_e;
        logic [1:0][3:0]   ln_e;
        logic [1:0][127:0] wd_e;
        int fp;
        int nreq [2];
        int cyc;
        m32  = ((32'd1 << len) - 32'd1) << a[3:0];
        span = {128'b0, wd} << {a[3:0], 3'b000};
        fp   = int'(a[4]);
        be_e[fp] = m32[15:0];      be_e[1-fp] = m32[31:16];
        ln_e[fp] = a[7:4];         ln_e[1-fp] = a[7:4] + 4'd1;
        wd_e[fp] = span[127:0];    wd_e[1-fp] = span[255:128];
        lat[0] = 1 + (opn % 3);
        lat[1] = 1 + ((opn / 3) % 3);
        opn++;
        nreq[0] = 0; nreq[1] = 0;
        req_valid_i = 1'b1; req_store_i = st; req_addr_i = a;
        req_len_i = 5'(len); req_wdata_i = wd;
        @(negedge clk);
        cyc = 1;
        req_valid_i = poke;
        if (poke) begin
            req_store_i = 1'b1; req_addr_i = 8'h80; req_len_i = 5'd16;
            req_wdata_i = {128{1'b1}};
        end
        chk("R1 busy after accept", 128'(req_busy_o), 128'(1));
        for (;;) begin
            for (int p = 0; p < 2; p++) begin
                if (mem_req_o[p]) begin
                    nreq[p]++;
                    chk("R5 request one cycle after accept", 128'(cyc), 128'(1));
                    chk("R3 line address", 128'(mem_line_o[p]), 128'(ln_e[p]));
                    chk("R4 byte enables", 128'(mem_be_o[p]), 128'(be_e[p]));
                    chk("R5 write enable", 128'(mem_we_o[p]), 128'(st));
                    if (st) chk("R6 write data", mem_wdata_o[p], wd_e[p]);
                end
            end
            if (rsp_valid_o || cyc >= 40) break;
            @(negedge clk);
            cyc++;
            req_valid_i = 1'b0;
        end
        req_valid_i = 1'b0;
        chk("R8 response seen", 128'(rsp_valid_o), 128'(1));
        for (int p = 0; p < 2; p++)
            chk("R5 requests per port", 128'(nreq[p]), 128'(be_e[p] != 16'h0));
        rd = rsp_rdata_o;
        if (st) begin
            chk("R7 store completion cycle", 128'(cyc), 128'(2));
            chk("R7 store response data", rd, 128'(0));
            for (int k = 0; k < len; k++) rmem[8'(a + 8'(k))] = wd[k*8 +: 8];
        end
        @(negedge clk);
        chk("R1 busy drops", 128'(req_busy_o), 128'(0));
        chk("R7 single pulse", 128'(rsp_valid_o), 128'(0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [127:0] rd;
        logic [7:0] bases [3];
        bases[0] = 8'h20; bases[1] = 8'h30; bases[2] = 8'hF0;
        for (int i = 0; i < 256; i++) rmem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 128'(req_busy_o), 128'(0));
        chk("R1 reset response", 128'(rsp_valid_o), 128'(0));
        chk("R1 reset memory requests", 128'(mem_req_o), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        // R10: all offsets and lengths from even, odd and top lines.
        for (int b = 0; b < 3; b++) begin
            for (int off = 0; off < 16; off++) begin
                for (int len = 1; len <= 16; len++) begin
                    logic [7:0] a;
                    logic [127:0] wd;
                    a = bases[b] + 8'(off);
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    wd = {lcg, ~lcg, lcg ^ 32'h5A5A_A5A5, {lcg[15:0], lcg[31:16]}};
                    do_op(1'b1, a, len, wd, 1'b0, rd);
                    do_op(1'b0, a, len, '0, 1'b0, rd);
                    chk("R9 load matches store", rd, exp_load(a, len));
                    do_op(1'b0, {a[7:4], 4'h0}, 16, '0, 1'b0, rd);
                    chk("R4 first line untouched bytes", rd, exp_load({a[7:4], 4'h0}, 16));
                    do_op(1'b0, {a[7:4] + 4'd1, 4'h0}, 16, '0, 1'b0, rd);
                    chk("R4 next line untouched bytes", rd, exp_load({a[7:4] + 4'd1, 4'h0}, 16));
                end
            end
        end
        // R2: requests made while busy are dropped.
        for (int i = 0; i < 4; i++) begin
            do_op(i[0], 8'h47 + 8'(i * 5), 9 + i, {4{32'hC0DE_0000 + 32'(i)}}, 1'b1, rd);
            if (!i[0]) chk("R9 load during poke", rd, exp_load(8'h47 + 8'(i * 5), 9 + i));
        end
        do_op(1'b0, 8'h80, 16, '0, 1'b0, rd);
        chk("R2 busy request ignored", rd, exp_load(8'h80, 16));
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule